// File: doc/BRIEF.md
# Amplifier Self-Healing Search Controller

This block closes the digital part of a self-healing loop around a power amplifier. It drives the amplifier's actuators: bias DAC codes, a force-off bit for the common-source bias DAC, and switch words for three tunable output stubs. It requests sensor readings from an acquisition unit and keeps the best actuation state found for the selected objective. Besides the mode and an output-power floor, the only command it takes is a single-cycle `run` strobe. Everything after that is autonomous.

A run first switches the amplifier off with the force-off bit and stores one reading of every sensor as its zero offset. It then steps an index through every actuation state in ascending order. For each state it applies the actuators, waits for one sensor reading and compares the offset-corrected result against the best so far. Delivered power is taken as forward detector minus reflected detector. Objective 0 maximises delivered power. Objective 1 minimises dc current among the states that reach the floor. At the end the chosen state is applied and stays applied, and `done` pulses for one cycle.

The state machine has five states. IDLE waits for `run`. CAL holds the force-off bit and requests the offset reading. SET applies the swept index for one cycle. MEAS requests a reading and evaluates it. FIN applies the result and pulses `done`. The transitions are:
- IDLE to CAL on `run`.
- CAL to SET on `sens_ack`.
- SET to MEAS unconditionally.
- MEAS to SET on `sens_ack` when the index is not the last one.
- MEAS to FIN on `sens_ack` at the last index.
- FIN to IDLE unconditionally.

Top module: `heal_ctrl`

## Requirements
- R1: A `run` pulse in IDLE starts a run, and `busy` is high from the following cycle until the cycle after `done`. A `run` pulse while a run is in progress has no effect: the sweep is neither restarted nor lengthened.
- R2: Each run makes exactly one offset request, and it is the first request of the run. `bias_off` is 1 throughout that request and 0 for every later request.
- R3: The reading taken during the offset request is subtracted from every later reading of the same sensor. A result that would be negative becomes 0.
- R4: A run makes exactly 2^N measurement requests after the offset request, with N = 3*STUB_SEL_W + 3*BIAS_SEL_W. They cover indices 0, 1, ... 2^N-1 in ascending order, one request per index. `sens_req` stays high until `sens_ack`.
- R5: Index bits [k*STUB_SEL_W +: STUB_SEL_W] select the length of stub k. Switch j of that stub's word (bit k*(2^STUB_SEL_W-1)+j of `stub_sw`) is on exactly when the select value exceeds j. Select 0 gives all switches off (longest stub); the top value gives all on (shortest).
- R6: Index bits [3*STUB_SEL_W + m*BIAS_SEL_W +: BIAS_SEL_W] form the upper bits of bias code m, and its lower DAC_W-BIAS_SEL_W bits are 0.
- R7: Delivered power is the corrected forward reading minus the corrected reflected reading, clamped at 0.
- R8: With `mode`=0, the result is the index with the largest delivered power. On a tie, the lowest index wins.
- R9: With `mode`=1, the result is the index with the smallest corrected dc current among those whose delivered power is at least `target`. On a tie, the lowest index wins. An index below the floor is never chosen.
- R10: With `mode`=1 and no index meeting the floor, `err` is 1 and index DEFAULT_IDX is applied.
- R11: `done` is high for exactly one cycle. In that cycle the actuators and `state_idx` already show the result, and they hold it until the next run. `err` also holds until the next run.
- R12: After reset, the block is idle: `busy`, `done`, `err`, `sens_req` and `bias_off` are 0, and index DEFAULT_IDX is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start strobe, one cycle |
| mode | input | 1 | Objective: 0 maximum delivered power, 1 minimum dc current above floor |
| target | input | SENS_W | Delivered-power floor for objective 1 |
| sens_ack | input | 1 | Sensor readings valid, one cycle |
| sens_fwd | input | SENS_W | Forward (coupled) detector reading |
| sens_rfl | input | SENS_W | Reflected (isolated) detector reading |
| sens_idc | input | SENS_W | DC current sensor reading |
| sens_req | output | 1 | Request one set of readings |
| bias_off | output | 1 | Force common-source bias DAC output to zero |
| bias_code | output | 3*DAC_W | Bias DAC codes, DAC m at bits [m*DAC_W +: DAC_W] |
| stub_sw | output | 3*(2^STUB_SEL_W-1) | Stub shorting switch words |
| state_idx | output | N | Applied actuation index |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, one cycle |
| err | output | 1 | No state met the floor in the last run |

## Verification
The bench builds the block with 2-bit stub selects and 1-bit bias selects. That gives a 9-bit index and 512 states, so about a dozen complete sweeps fit in the run time. The 3-bit switch words still exercise the thermometer encoding at every select value. The index width follows from the parameters alone, so the full 18-bit space differs only in counter width and sweep length. The bench's sensor model adds fixed offsets and reads the applied state back from the actuator ports. Its response patterns are chosen to expose first-found ties, a forward-only power estimate, unclamped subtraction, and a floor set exactly at or one above the best delivered power.

// File: rtl/heal_pkg.sv
package heal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAL,
        ST_SET,
        ST_MEAS,
        ST_FIN
    } heal_state_e;

    typedef enum logic {
        OBJ_MAX_POUT = 1'b0,
        OBJ_MIN_DC   = 1'b1
    } heal_obj_e;

endpackage

// File: rtl/heal_decode.sv
module heal_decode #(
    parameter int NUM_STUB   = 3,
    parameter int STUB_SEL_W = 3,
    parameter int NUM_BIAS   = 3,
    parameter int BIAS_SEL_W = 3,
    parameter int DAC_W      = 6,
    localparam int SW_W      = (1 << STUB_SEL_W) - 1,
    localparam int IDX_W     = NUM_STUB * STUB_SEL_W + NUM_BIAS * BIAS_SEL_W
) (
    input  logic [IDX_W-1:0]          idx,
    output logic [NUM_STUB*SW_W-1:0]  stub_sw,
    output logic [NUM_BIAS*DAC_W-1:0] bias_code
);

    localparam int BIAS_BASE = NUM_STUB * STUB_SEL_W;

    // Thermometer word per stub: switch j on when the select exceeds j
    for (genvar k = 0; k < NUM_STUB; k++) begin : g_stub
        logic [STUB_SEL_W-1:0] sel;
        assign sel = idx[k*STUB_SEL_W +: STUB_SEL_W];
        for (genvar j = 0; j < SW_W; j++) begin : g_sw
            assign stub_sw[k*SW_W + j] = (int'(sel) > j);
        end
    end

    // Bias select drives the upper bits of each DAC code
    for (genvar m = 0; m < NUM_BIAS; m++) begin : g_bias
        assign bias_code[m*DAC_W +: DAC_W] =
            {idx[BIAS_BASE + m*BIAS_SEL_W +: BIAS_SEL_W], {(DAC_W-BIAS_SEL_W){1'b0}}};
    end

endmodule

// File: rtl/heal_offset.sv
module heal_offset #(
    parameter int SENS_W = 10,
    parameter int NCH    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap,
    input  logic [NCH-1:0][SENS_W-1:0]   raw,
    output logic [NCH-1:0][SENS_W-1:0]   corr
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SENS_W-1:0] zero_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                zero_q <= '0;
            end else if (cap) begin
                zero_q <= raw[c];
            end
        end

        assign corr[c] = (raw[c] > zero_q) ? raw[c] - zero_q : '0;
    end

endmodule

// File: rtl/heal_judge.sv
module heal_judge
    import heal_pkg::*;
#(
    parameter int SENS_W = 10
) (
    input  heal_obj_e         obj,
    input  logic [SENS_W-1:0] floor_lvl,
    input  logic [SENS_W-1:0] fwd,
    input  logic [SENS_W-1:0] rfl,
    input  logic [SENS_W-1:0] idc,
    input  logic              have_best,
    input  logic [SENS_W-1:0] best_pout,
    input  logic [SENS_W-1:0] best_idc,
    output logic [SENS_W-1:0] pout,
    output logic              better
);

    logic qual;

    always_comb begin
        pout = (fwd > rfl) ? fwd - rfl : '0;
        qual = (pout >= floor_lvl);
        unique case (obj)
            OBJ_MAX_POUT: better = !have_best || (pout > best_pout);
            OBJ_MIN_DC:   better = qual && (!have_best || (idc < best_idc));
        endcase
    end

endmodule

// File: rtl/heal_ctrl.sv
module heal_ctrl
    import heal_pkg::*;
#(
    parameter int NUM_STUB    = 3,
    parameter int STUB_SEL_W  = 3,
    parameter int NUM_BIAS    = 3,
    parameter int BIAS_SEL_W  = 3,
    parameter int DAC_W       = 6,
    parameter int SENS_W      = 10,
    parameter int DEFAULT_IDX = 0,
    localparam int SW_W       = (1 << STUB_SEL_W) - 1,
    localparam int IDX_W      = NUM_STUB * STUB_SEL_W + NUM_BIAS * BIAS_SEL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      mode,
    input  logic [SENS_W-1:0]         target,
    input  logic                      sens_ack,
    input  logic [SENS_W-1:0]         sens_fwd,
    input  logic [SENS_W-1:0]         sens_rfl,
    input  logic [SENS_W-1:0]         sens_idc,
    output logic                      sens_req,
    output logic                      bias_off,
    output logic [NUM_BIAS*DAC_W-1:0] bias_code,
    output logic [NUM_STUB*SW_W-1:0]  stub_sw,
    output logic [IDX_W-1:0]          state_idx,
    output logic                      busy,
    output logic                      done,
    output logic                      err
);

    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] DEF_IDX  = IDX_W'(DEFAULT_IDX);

    heal_state_e st_q, st_d;
    heal_obj_e   obj_q;

    logic [IDX_W-1:0]  scan_q, cur_q, best_idx_q, act_idx;
    logic [SENS_W-1:0] best_pout_q, best_idc_q, floor_q, pout;
    logic              have_q, err_q, better, have_next;
    logic              cal_cap, meas_ok, at_last;
    logic [2:0][SENS_W-1:0] raw, corr;

    assign raw       = {sens_idc, sens_rfl, sens_fwd};
    assign cal_cap   = (st_q == ST_CAL) && sens_ack;
    assign meas_ok   = (st_q == ST_MEAS) && sens_ack;
    assign at_last   = (scan_q == LAST_IDX);
    assign have_next = have_q || better;

    heal_offset #(.SENS_W(SENS_W), .NCH(3)) u_offset (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (cal_cap),
        .raw  (raw),
        .corr (corr)
    );

    heal_judge #(.SENS_W(SENS_W)) u_judge (
        .obj      (obj_q),
        .floor_lvl(floor_q),
        .fwd      (corr[0]),
        .rfl      (corr[1]),
        .idc      (corr[2]),
        .have_best(have_q),
        .best_pout(best_pout_q),
        .best_idc (best_idc_q),
        .pout     (pout),
        .better   (better)
    );

    heal_decode #(
        .NUM_STUB  (NUM_STUB),
        .STUB_SEL_W(STUB_SEL_W),
        .NUM_BIAS  (NUM_BIAS),
        .BIAS_SEL_W(BIAS_SEL_W),
        .DAC_W     (DAC_W)
    ) u_decode (
        .idx      (act_idx),
        .stub_sw  (stub_sw),
        .bias_code(bias_code)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (run)      st_d = ST_CAL;
            ST_CAL:  if (sens_ack) st_d = ST_SET;
            ST_SET:                st_d = ST_MEAS;
            ST_MEAS: if (sens_ack) st_d = at_last ? ST_FIN : ST_SET;
            ST_FIN:                st_d = ST_IDLE;
            default:               st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q      <= '0;
            cur_q       <= DEF_IDX;
            best_idx_q  <= '0;
            best_pout_q <= '0;
            best_idc_q  <= '0;
            have_q      <= 1'b0;
            err_q       <= 1'b0;
            obj_q       <= OBJ_MAX_POUT;
            floor_q     <= '0;
        end else begin
            if (st_q == ST_IDLE && run) begin
                obj_q   <= heal_obj_e'(mode);
                floor_q <= target;
                scan_q  <= '0;
                have_q  <= 1'b0;
                err_q   <= 1'b0;
            end
            if (meas_ok) begin
                if (better) begin
                    best_idx_q  <= scan_q;
                    best_pout_q <= pout;
                    best_idc_q  <= corr[2];
                end
                have_q <= have_next;
                if (at_last) begin
                    cur_q <= !have_next ? DEF_IDX : (better ? scan_q : best_idx_q);
                    err_q <= !have_next;
                end else begin
                    scan_q <= scan_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        act_idx   = (st_q == ST_SET || st_q == ST_MEAS) ? scan_q : cur_q;
        sens_req  = (st_q == ST_CAL) || (st_q == ST_MEAS);
        bias_off  = (st_q == ST_CAL);
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_FIN);
        err       = err_q;
        state_idx = cur_q;
    end

    AST_CAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> bias_off);                                               // R2
    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_off && sens_ack) |=> !bias_off);                                   // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sens_req && !sens_ack) |=> sens_req);                                   // R4
    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_ok && !at_last) |=> (scan_q == $past(scan_q) + 1'b1));             // R4
    AST_RUN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && run) |=> busy);                                        // R1
    AST_FLOOR_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && obj_q == OBJ_MIN_DC) |-> (best_pout_q >= floor_q));     // R9
    AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (state_idx == DEF_IDX));                               // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                         // R11
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(stub_sw) && $stable(bias_code)));                     // R11

endmodule

// File: tb/heal_ctrl_tb.sv
module heal_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS  = 3;
    localparam int SS  = 2;
    localparam int NB  = 3;
    localparam int BS  = 1;
    localparam int DW  = 6;
    localparam int SNW = 10;
    localparam int DEF = 165;
    localparam int SWW = 3;
    localparam int IW  = 9;
    localparam int NST = 512;
    localparam int OFF_F = 5;
    localparam int OFF_R = 3;
    localparam int OFF_I = 7;

    // vector: {mode[12], target[11:2], pattern[1:0]}
    localparam logic [12:0] RUNS [8] = '{
        {1'b0, 10'd0,    2'd0},
        {1'b1, 10'd350,  2'd0},
        {1'b0, 10'd0,    2'd1},
        {1'b1, 10'd300,  2'd1},
        {1'b0, 10'd0,    2'd2},
        {1'b1, 10'd450,  2'd2},
        {1'b0, 10'd0,    2'd3},
        {1'b1, 10'd1000, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic mode = 1'b0;
    logic [SNW-1:0] target = '0;
    logic sens_ack = 1'b0;
    logic [SNW-1:0] sens_fwd = '0, sens_rfl = '0, sens_idc = '0;
    logic sens_req, bias_off, busy, done, err;
    logic [NB*DW-1:0] bias_code;
    logic [NS*SWW-1:0] stub_sw;
    logic [IW-1:0] state_idx;

    int checks = 0;
    int errors = 0;
    int pat = 0;
    int req_cnt = 0, cal_cnt = 0, ord_err = 0, exp_next = 0;
    bit cal_first = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    heal_ctrl #(
        .NUM_STUB(NS), .STUB_SEL_W(SS), .NUM_BIAS(NB), .BIAS_SEL_W(BS),
        .DAC_W(DW), .SENS_W(SNW), .DEFAULT_IDX(DEF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .target(target),
        .sens_ack(sens_ack), .sens_fwd(sens_fwd), .sens_rfl(sens_rfl),
        .sens_idc(sens_idc), .sens_req(sens_req), .bias_off(bias_off),
        .bias_code(bias_code), .stub_sw(stub_sw), .state_idx(state_idx),
        .busy(busy), .done(done), .err(err)
    );

    function automatic int pf(int p, int s);
        case (p)
            0: return (s * 37) % 200 + 300;
            1: return (s >= 300) ? 400 : 200;
            2: return 500;
            default: return 10;
        endcase
    endfunction

    function automatic int pr(int p, int s);
        case (p)
            0: return (s * 11) % 100;
            1: return 0;
            2: return (s == 77) ? 0 : (s % 50) + 10;
            default: return (s == 200) ? 0 : 40;
        endcase
    endfunction

    function automatic int pi(int p, int s);
        case (p)
            0: return (s * 13) % 150 + 10;
            1: return 50;
            2: return 600 - s;
            default: return 20;
        endcase
    endfunction

    function automatic int pout_of(int p, int s);
        int d = pf(p, s) - pr(p, s);
        return (d > 0) ? d : 0;
    endfunction

    function automatic int exp_stub(int s);
        int r = 0;
        for (int k = 0; k < NS; k++) begin
            int sel = (s >> (SS*k)) & 3;
            r |= ((1 << sel) - 1) << (SWW*k);
        end
        return r;
    endfunction

    function automatic int exp_bias(int s);
        int r = 0;
        for (int j = 0; j < NB; j++) begin
            int b = (s >> (NS*SS + j)) & 1;
            r |= (b << (DW-BS)) << (DW*j);
        end
        return r;
    endfunction

    task automatic ref_best(input int md, input int tgt, input int p,
                            output int idx, output int e);
        bit have = 1'b0;
        int bp = 0, bi = 0;
        idx = DEF;
        e = 0;
        for (int s = 0; s < NST; s++) begin
            int po = pout_of(p, s);
            if (md == 0) begin
                if (!have || po > bp) begin have = 1'b1; bp = po; idx = s; end
            end else if (po >= tgt && (!have || pi(p, s) < bi)) begin
                have = 1'b1; bi = pi(p, s); idx = s;
            end
        end
        if (!have) begin idx = DEF; e = 1; end
    endtask

    // Behavioural sensor unit: replies one cycle after a request
    always @(negedge clk) begin
        int s;
        sens_ack <= 1'b0;
        if (sens_req && !sens_ack) begin
            if (bias_off) begin
                if (req_cnt == 0) cal_first = 1'b1;
                cal_cnt++;
                exp_next = 0;
                sens_fwd <= SNW'(OFF_F);
                sens_rfl <= SNW'(OFF_R);
                sens_idc <= SNW'(OFF_I);
            end else begin
                s = 0;
                for (int k = 0; k < NS; k++)
                    s |= $countones(stub_sw[k*SWW +: SWW]) << (SS*k);
                for (int j = 0; j < NB; j++)
                    s |= int'(bias_code[j*DW +: DW] >> (DW-BS)) << (NS*SS + j);
                if (s != exp_next) ord_err++;
                exp_next = s + 1;
                sens_fwd <= SNW'(pf(pat, s) + OFF_F);
                sens_rfl <= SNW'(pr(pat, s) + OFF_R);
                sens_idc <= SNW'(pi(pat, s) + OFF_I);
            end
            req_cnt++;
            sens_ack <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic do_run(input int md, input int tgt, input int p,
                          input string tag, input bit extra_run);
        int eidx, eerr;
        bit got = 1'b0;
        ref_best(md, tgt, p, eidx, eerr);
        pat = p;
        req_cnt = 0; cal_cnt = 0; ord_err = 0; cal_first = 1'b0;
        mode = md[0];
        target = SNW'(tgt);
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        chk(busy == 1'b1, "R1 busy after run", int'(busy), 1);
        if (extra_run) begin
            repeat (100) @(negedge clk);
            run = 1'b1;
            @(negedge clk);
            run = 1'b0;
        end
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk);
            if (done) begin got = 1'b1; break; end
        end
        chk(got, "R11 done seen (watchdog)", int'(got), 1);
        if (!got) return;
        chk(err == eerr[0], "R10 err flag", int'(err), eerr);
        chk(state_idx == IW'(eidx), tag, int'(state_idx), eidx);
        chk(stub_sw == (NS*SWW)'(exp_stub(eidx)), "R5 stub words", int'(stub_sw), exp_stub(eidx));
        chk(bias_code == (NB*DW)'(exp_bias(eidx)), "R6 bias codes", int'(bias_code), exp_bias(eidx));
        chk(cal_cnt == 1 && cal_first, "R2 single offset request first", cal_cnt, 1);
        chk(req_cnt == NST + 1, extra_run ? "R1 run ignored while busy" : "R4 request count",
            req_cnt, NST + 1);
        chk(ord_err == 0, "R4 ascending order", ord_err, 0);
        repeat (5) @(negedge clk);
        chk(!done && !busy, "R11 done single cycle", int'(done), 0);
        chk(stub_sw == (NS*SWW)'(exp_stub(eidx)) && state_idx == IW'(eidx),
            "R11 result held", int'(state_idx), eidx);
    endtask

    initial begin
        int maxp = 0;
        for (int s = 0; s < NST; s++)
            if (pout_of(0, s) > maxp) maxp = pout_of(0, s);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !done && !err, "R12 flags after reset", int'({busy, done, err}), 0);
        chk(!sens_req && !bias_off, "R12 no request, amplifier on", int'({sens_req, bias_off}), 0);
        chk(state_idx == IW'(DEF), "R12 default index", int'(state_idx), DEF);
        chk(stub_sw == (NS*SWW)'(exp_stub(DEF)), "R12 default stub words", int'(stub_sw), exp_stub(DEF));

        for (int v = 0; v < 8; v++) begin
            int md = int'(RUNS[v][12]);
            int tg = int'(RUNS[v][11:2]);
            int pp = int'(RUNS[v][1:0]);
            string tag;
            if (pp >= 2 && md == 0) tag = "R7 reflected power used";
            else if (md == 0)       tag = "R8 max power index";
            else                    tag = "R9 min dc index";
            do_run(md, tg, pp, tag, 1'b0);
        end

        // R3 offsets removed: floor exactly at the best power qualifies, one above fails
        do_run(1, maxp, 0, "R3 floor at best power", 1'b0);
        chk(err == 1'b0, "R3 floor reachable", int'(err), 0);
        do_run(1, maxp + 1, 0, "R3 floor above best power", 1'b0);
        chk(err == 1'b1, "R3 floor unreachable", int'(err), 1);

        // R1 run strobe during a sweep
        do_run(0, 0, 0, "R8 after ignored run", 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule